// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block is the software-visible register bank of a UART. A host reaches it over a simple 32-bit register bus that carries an address, a write strobe with write data, and a read strobe with combinational read data. Eight byte-wide registers sit at word-spaced offsets. A write to the data offset loads a character for transmission. The block hands that character, trimmed to the configured word length, to a downstream serialiser over a valid/ready byte handshake. Bytes from the receive side arrive over a second valid/ready handshake, and a read of the same offset collects them.

A line-status register reports whether the transmit holding register is empty and whether received data is waiting. An identification register records which event last called for attention, using one-hot codes. A single level interrupt output combines those events with the per-source enables. Serial timing, the divisor's effect on baud rate, parity and the modem lines are handled elsewhere. The modem-control, modem-status and divisor registers only store what software writes.

Top module: `uart_regbank`

## Requirements
- R1: After reset, every register reads 0x00 except line status, which reads 0x20. `irq` and `tx_valid` are low and `rx_ready` is high.
- R2: Registers are 8 bits wide at byte offsets 0x04 interrupt enable, 0x08 identification, 0x0C line control, 0x10 modem control, 0x18 modem status and 0x1C divisor. A write stores the low byte, and a read returns it with the upper bus bits zero.
- R3: A write to offset 0x00 stores the byte and clears line-status bit 5 and identification bit 1. It raises `tx_valid` in the next cycle.
- R4: `tx_data` is the stored byte masked by line-control bits [1:0]: 00 keeps 5 bits (0x1F), 01 keeps 6 bits (0x3F), 10 keeps 7 bits (0x7F) and 11 keeps all 8.
- R5: While `tx_ready` is low, `tx_valid` stays high and `tx_data` holds steady. The edge that samples `tx_ready` high completes the transfer: line-status bit 5 sets and identification becomes exactly 0x02.
- R6: `irq` is high when (enable bit 1 and identification bit 1) or (enable bit 0 and identification bit 2). A completed transfer therefore raises `irq` only when enable bit 1 is set.
- R7: A write to the enable register with bit 1 set, while line-status bit 5 is set, sets identification bit 1 at the same edge, so `irq` rises at once. A write with bits 1 and 0 both clear leaves `irq` low.
- R8: `rx_ready` equals the inverse of line-status bit 0. A byte offered with `rx_valid` while `rx_ready` is high is captured. This sets line-status bit 0 and identification bit 2, and a byte offered while `rx_ready` is low is not captured.
- R9: A read of offset 0x00 returns the captured byte and clears line-status bit 0 and identification bit 2.
- R10: A read of any offset that is unaligned or above 0x1C returns 0, and a write to such an offset changes no register.
- R11: A write to line status (0x14) stores only bits 7:6 and 4:1. Bits 0 and 5 keep reflecting receive and transmit state.
- R12: A data write in the same cycle that a transfer completes is taken as a new character: `tx_valid` stays high with the new byte, and line-status bit 5 and identification bit 1 end clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects occur at the clock edge |
| bus_wdata | input | BUS_W | Write data; the low byte is used |
| bus_rdata | output | BUS_W | Read data, zero when not reading |
| irq | output | 1 | Level interrupt |
| tx_data | output | 8 | Masked transmit character |
| tx_valid | output | 1 | Transmit character pending |
| tx_ready | input | 1 | Downstream accepts the character |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive buffer empty and able to capture |

## Verification
The bench builds the block with the defaults ADDR_W = 8 and BUS_W = 32. An 8-bit address reaches unmapped space above 0x1C as well as unaligned offsets inside the map, so the R10 checks cover both kinds of miss. A 32-bit data bus lets the checks confirm that the upper read bits stay zero and that upper write bits are dropped, for example by reading back the divisor after a wide write. The scoreboard checks every transmit completion against the masked byte predicted at write time. This includes the case where a write collides with a completion.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int CHAR_W  = 8;
    localparam int SEL_W   = 3;
    localparam int MAP_TOP = 5;  // address bits spanned by the map

    // Register selector; the value times four is the byte offset.
    typedef enum logic [SEL_W-1:0] {
        RS_DATA  = 3'd0,
        RS_IEN   = 3'd1,
        RS_IID   = 3'd2,
        RS_LCTL  = 3'd3,
        RS_MCTL  = 3'd4,
        RS_LSTAT = 3'd5,
        RS_MSTAT = 3'd6,
        RS_DIVR  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } decode_t;

    localparam logic [CHAR_W-1:0] IID_TX    = 8'h02;
    localparam logic [CHAR_W-1:0] IID_RX    = 8'h04;
    localparam int                IEN_RX    = 0;
    localparam int                IEN_TX    = 1;
    localparam int                LS_RX     = 0;
    localparam int                LS_TX     = 5;
    localparam logic [CHAR_W-1:0] LS_STORED = 8'hDE;

    // 00 -> 0x1F, 01 -> 0x3F, 10 -> 0x7F, 11 -> 0xFF
    function automatic logic [CHAR_W-1:0] width_mask(input logic [1:0] wls);
        logic [CHAR_W:0] m;
        m = (9'h020 << wls) - 9'h001;
        return m[CHAR_W-1:0];
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_byte,
    input  logic [1:0]        wls,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              done,
    output logic              empty
);
    logic [CHAR_W-1:0] hold_q;
    logic              pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            hold_q <= load_byte;
            pend_q <= 1'b1;
        end else if (pend_q && tx_ready) begin
            pend_q <= 1'b0;
        end
    end

    assign tx_valid = pend_q;
    assign tx_data  = hold_q & width_mask(wls);
    assign done     = pend_q & tx_ready;
    assign empty    = ~pend_q;

    // R3
    load_raises_valid_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> tx_valid);

    // R5
    stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(hold_q)));

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_byte,
    input  logic              take,
    output logic [CHAR_W-1:0] rbr,
    output logic              full,
    output logic              accept,
    output logic              taken
);
    logic [CHAR_W-1:0] rbr_q;
    logic              full_q;

    assign accept = in_valid & ~full_q;
    assign taken  = take & full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr_q  <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            rbr_q  <= in_byte;
            full_q <= 1'b1;
        end else if (taken) begin
            full_q <= 1'b0;
        end
    end

    assign rbr  = rbr_q;
    assign full = full_q;

    // R8
    capture_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full) |=> full);

    // R8
    full_keeps_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(rbr)));

    // R9
    read_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (full && take) |=> !full);

endmodule

// File: rtl/uart_int_id.sv
module uart_int_id
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ien_wr,
    input  logic              iid_wr,
    input  logic [CHAR_W-1:0] wbyte,
    input  logic              tx_done,
    input  logic              tx_load,
    input  logic              tx_empty,
    input  logic              rx_accept,
    input  logic              rx_taken,
    output logic [CHAR_W-1:0] ien,
    output logic [CHAR_W-1:0] iid,
    output logic              irq
);
    logic [CHAR_W-1:0] ien_q, iid_q, iid_d;

    always_comb begin
        iid_d = iid_q;
        if (tx_done)   iid_d = IID_TX;
        if (rx_accept) iid_d = iid_d | IID_RX;
        if (rx_taken)  iid_d = iid_d & ~IID_RX;
        if (tx_load)   iid_d = iid_d & ~IID_TX;
        if (ien_wr && wbyte[IEN_TX] && tx_empty) iid_d = iid_d | IID_TX;
        if (iid_wr)    iid_d = wbyte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            iid_q <= '0;
        end else begin
            iid_q <= iid_d;
            if (ien_wr) ien_q <= wbyte;
        end
    end

    assign ien = ien_q;
    assign iid = iid_q;
    assign irq = (ien_q[IEN_TX] & iid_q[1]) | (ien_q[IEN_RX] & iid_q[2]);

    // R5
    done_marks_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !tx_load && !iid_wr) |=> (iid == IID_TX));

    // R7
    enable_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_wr && wbyte[IEN_TX] && tx_empty) |=> irq);

    // R7
    disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ien_wr && wbyte[1:0] == 2'b00) |=> !irq);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready
);
    localparam int PAD_W = BUS_W - CHAR_W;

    decode_t           dec;
    logic [CHAR_W-1:0] wbyte;
    logic              wr_data, wr_ien, wr_iid, rd_data;
    logic [CHAR_W-1:0] lctl_q, mctl_q, mstat_q, divr_q, lsmisc_q;
    logic              tx_done, tx_empty, rx_full, rx_accept, rx_taken;
    logic [CHAR_W-1:0] rbr, ien, iid, lstat, rd_byte;

    always_comb begin
        dec.hit = (bus_addr[1:0] == 2'b00) && ((bus_addr >> MAP_TOP) == '0);
        dec.sel = reg_sel_e'(bus_addr[MAP_TOP-1:2]);
    end

    assign wbyte   = bus_wdata[CHAR_W-1:0];
    assign wr_data = bus_wr && dec.hit && dec.sel == RS_DATA;
    assign wr_ien  = bus_wr && dec.hit && dec.sel == RS_IEN;
    assign wr_iid  = bus_wr && dec.hit && dec.sel == RS_IID;
    assign rd_data = bus_rd && dec.hit && dec.sel == RS_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            lctl_q   <= '0;
            mctl_q   <= '0;
            mstat_q  <= '0;
            divr_q   <= '0;
            lsmisc_q <= '0;
        end else if (bus_wr && dec.hit) begin
            case (dec.sel)
                RS_LCTL:  lctl_q   <= wbyte;
                RS_MCTL:  mctl_q   <= wbyte;
                RS_MSTAT: mstat_q  <= wbyte;
                RS_DIVR:  divr_q   <= wbyte;
                RS_LSTAT: lsmisc_q <= wbyte & LS_STORED;
                default:  ;
            endcase
        end
    end

    uart_tx_hold u_tx (
        .clk(clk), .rst(rst), .load(wr_data), .load_byte(wbyte),
        .wls(lctl_q[1:0]), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_valid(tx_valid), .done(tx_done), .empty(tx_empty)
    );

    uart_rx_hold u_rx (
        .clk(clk), .rst(rst), .in_valid(rx_valid), .in_byte(rx_data),
        .take(rd_data), .rbr(rbr), .full(rx_full), .accept(rx_accept),
        .taken(rx_taken)
    );

    uart_int_id u_int (
        .clk(clk), .rst(rst), .ien_wr(wr_ien), .iid_wr(wr_iid), .wbyte(wbyte),
        .tx_done(tx_done), .tx_load(wr_data), .tx_empty(tx_empty),
        .rx_accept(rx_accept), .rx_taken(rx_taken), .ien(ien), .iid(iid),
        .irq(irq)
    );

    assign rx_ready = ~rx_full;

    always_comb begin
        lstat        = lsmisc_q;
        lstat[LS_RX] = rx_full;
        lstat[LS_TX] = tx_empty;
    end

    always_comb begin
        case (dec.sel)
            RS_DATA:  rd_byte = rbr;
            RS_IEN:   rd_byte = ien;
            RS_IID:   rd_byte = iid;
            RS_LCTL:  rd_byte = lctl_q;
            RS_MCTL:  rd_byte = mctl_q;
            RS_LSTAT: rd_byte = lstat;
            RS_MSTAT: rd_byte = mstat_q;
            default:  rd_byte = divr_q;
        endcase
        bus_rdata = (bus_rd && dec.hit) ? {{PAD_W{1'b0}}, rd_byte} : '0;
    end

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !dec.hit) |-> (bus_rdata == '0));

    // R8
    ready_tracks_status_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ready == !lstat[LS_RX]);

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int BUS_W      = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [BUS_W-1:0]  bus_wdata = '0;
    logic [BUS_W-1:0]  bus_rdata;
    logic              irq, tx_valid, rx_ready;
    logic              tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]        tx_data, rx_data = '0;

    int         n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    logic [1:0] cur_wls = 2'b00;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regbank #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d, exp);
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] w);
        case (w)
            2'b00:   return 8'h1F;
            2'b01:   return 8'h3F;
            2'b10:   return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    // Driver: predict the masked byte, then write the data offset.
    task automatic send_char(input logic [7:0] b);
        exp_q.push_back(b & mask_of(cur_wls));
        bus_write(8'h00, {24'h0, b});
    endtask

    task automatic set_wls(input logic [1:0] w);
        cur_wls = w;
        bus_write(8'h0C, {30'h0, w});
    endtask

    task automatic rx_pulse(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    // Monitor: each completed transfer is compared with the oldest prediction (R4, R5).
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected transfer", {24'h0, tx_data}, 32'hFFFF_FFFF);
            end else begin
                chk("R4 transmitted byte", {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 tx_valid", {31'h0, tx_valid}, 0);
        chk("R1 rx_ready", {31'h0, rx_ready}, 1);
        read_chk("R1 ien", 8'h04, 0);
        read_chk("R1 iid", 8'h08, 0);
        read_chk("R1 lctl", 8'h0C, 0);
        read_chk("R1 mctl", 8'h10, 0);
        read_chk("R1 lstat", 8'h14, 32'h20);
        read_chk("R1 mstat", 8'h18, 0);
        read_chk("R1 divr", 8'h1C, 0);
        read_chk("R1 data", 8'h00, 0);

        // R2 storage
        set_wls(2'b11);
        bus_write(8'h10, 32'hFFFF_FFA5);
        bus_write(8'h18, 32'h0000_005A);
        bus_write(8'h1C, 32'h0000_1234);
        bus_write(8'h08, 32'h0000_0080);
        read_chk("R2 lctl", 8'h0C, 32'h03);
        read_chk("R2 mctl", 8'h10, 32'hA5);
        read_chk("R2 mstat", 8'h18, 32'h5A);
        read_chk("R2 divr", 8'h1C, 32'h34);
        read_chk("R2 iid", 8'h08, 32'h80);
        bus_write(8'h08, 32'h0);

        // R10 unmapped offsets
        bus_write(8'h20, 32'hFF);
        bus_write(8'h0D, 32'h00);
        bus_write(8'hFC, 32'h77);
        read_chk("R10 read above map", 8'h20, 0);
        read_chk("R10 read unaligned", 8'h06, 0);
        read_chk("R10 lctl unchanged", 8'h0C, 32'h03);
        read_chk("R10 divr unchanged", 8'h1C, 32'h34);

        // R3 / R5 stalled transfer
        tx_ready = 1'b0;
        send_char(8'hC3);
        chk("R3 tx_valid", {31'h0, tx_valid}, 1);
        read_chk("R3 lstat", 8'h14, 32'h00);
        read_chk("R3 iid", 8'h08, 32'h00);
        chk("R5 data held", {24'h0, tx_data}, 32'hC3);
        @(posedge clk); #1;
        chk("R5 still valid", {31'h0, tx_valid}, 1);
        chk("R5 data stable", {24'h0, tx_data}, 32'hC3);
        tx_ready = 1'b1;
        @(posedge clk); #1;
        chk("R5 done", {31'h0, tx_valid}, 0);
        read_chk("R5 lstat", 8'h14, 32'h20);
        read_chk("R5 iid", 8'h08, 32'h02);
        chk("R6 no irq when disabled", {31'h0, irq}, 0);

        // R4 word lengths
        for (int w = 0; w < 3; w++) begin
            set_wls(w[1:0]);
            send_char(8'hFF);
            @(posedge clk); #1;
        end
        set_wls(2'b01);
        send_char(8'hA6);
        @(posedge clk); #1;
        set_wls(2'b11);

        // R7 enable while empty
        bus_write(8'h08, 32'h0);
        bus_write(8'h04, 32'h02);
        chk("R7 irq at once", {31'h0, irq}, 1);
        read_chk("R7 iid", 8'h08, 32'h02);
        bus_write(8'h04, 32'h00);
        chk("R7 irq off", {31'h0, irq}, 0);

        // R6 completion with enable
        bus_write(8'h04, 32'h02);
        tx_ready = 1'b0;
        send_char(8'h33);
        chk("R6 load clears irq", {31'h0, irq}, 0);
        tx_ready = 1'b1;
        @(posedge clk); #1;
        chk("R6 irq on completion", {31'h0, irq}, 1);
        bus_write(8'h04, 32'h00);
        bus_write(8'h08, 32'h00);

        // R8 / R9 receive
        bus_write(8'h04, 32'h01);
        chk("R8 irq idle", {31'h0, irq}, 0);
        rx_pulse(8'h5E);
        chk("R8 rx_ready low", {31'h0, rx_ready}, 0);
        chk("R8 irq", {31'h0, irq}, 1);
        read_chk("R8 lstat", 8'h14, 32'h21);
        read_chk("R8 iid", 8'h08, 32'h04);
        rx_pulse(8'h11);
        read_chk("R9 data", 8'h00, 32'h5E);
        read_chk("R9 lstat", 8'h14, 32'h20);
        read_chk("R9 iid", 8'h08, 32'h00);
        chk("R9 irq", {31'h0, irq}, 0);
        chk("R8 rx_ready back", {31'h0, rx_ready}, 1);
        bus_write(8'h04, 32'h00);

        // R11 line-status writes
        bus_write(8'h14, 32'hFF);
        read_chk("R11 stored bits", 8'h14, 32'hFE);
        bus_write(8'h14, 32'h00);
        read_chk("R11 cleared", 8'h14, 32'h20);

        // R12 write collides with completion
        tx_ready = 1'b0;
        send_char(8'h41);
        tx_ready = 1'b1;
        send_char(8'h42);
        chk("R12 still valid", {31'h0, tx_valid}, 1);
        chk("R12 new byte", {24'h0, tx_data}, 32'h42);
        tx_ready = 1'b0;
        read_chk("R12 lstat", 8'h14, 32'h00);
        read_chk("R12 iid", 8'h08, 32'h00);
        tx_ready = 1'b1;
        repeat (3) @(posedge clk); #1;

        chk("R5 scoreboard drained", exp_q.size(), 0);
        report();
    end
endmodule